// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Controller

This block is the bus-facing half of a two-wire (I2C) serial EEPROM. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It decodes a 7-bit device address and direction bit, then steers the transaction. On a write it captures the byte address and data bytes. On a read it serialises bytes supplied by the pointer unit. It drives SDA only through a pull-low enable.

Its neighbours are an address pointer unit, which loads on `ptr_load_o`, advances on `rd_next_o` and presents the byte at the pointer on `rd_data_i`. A page write buffer takes `wbuf_wr_o`/`wbuf_data_o`. A write-cycle timer starts on `wr_start_o` and reports `busy_i` while the non-volatile write runs. The write-protect pin arrives on `wp_i`.

Top module: `eei2c_target`

## Requirements
- R1: After reset SDA is released (`sda_low_o`=0), and bus activity without a START condition (SDA falling while SCL is high) is never acknowledged.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling SDA low during the ninth SCL pulse, for either value of the direction bit (bit 0, 0 = write, 1 = read).
- R3: After an address byte that does not match, SDA is not driven again until the next START, so later bytes see no acknowledge.
- R4: While `busy_i` is high a matching address byte is not acknowledged.
- R5: In a write, the byte after the address is acknowledged and presented on `ptr_addr_o` with a one-cycle `ptr_load_o` strobe.
- R6: Each later data byte is acknowledged and handed to the page buffer as `wbuf_data_o` with a one-cycle `wbuf_wr_o` strobe, in bus order; at most one neighbour strobe is active in any cycle.
- R7: A STOP (SDA rising while SCL is high) that ends a write with at least one accepted data byte gives exactly one `wr_start_o` pulse. A STOP with no accepted data byte gives none. A START discards data accepted before it.
- R8: `wp_i` is sampled on the SCL falling edge that ends the byte-address acknowledge. If it was high, the first data byte is not acknowledged, is not forwarded, and the following STOP starts no write. A change of `wp_i` after that edge has no effect on the transaction.
- R9: After an acknowledged read address, bytes from `rd_data_i` are shifted out most significant bit first. `rd_next_o` pulses once after each byte.
- R10: SDA is released for the master's acknowledge bit. An acknowledge (SDA low) starts the next byte from the advanced pointer. A non-acknowledge leaves SDA released until the next START or STOP.
- R11: A repeated START after the byte address, followed by a read address, reads from that byte address and starts no write.
- R12: `sda_low_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad, asynchronous |
| sda_low_o | output | 1 | Pull SDA low when 1, release when 0 |
| busy_i | input | 1 | Non-volatile write cycle in progress |
| wp_i | input | 1 | Write-protect pin, asynchronous |
| ptr_load_o | output | 1 | Strobe: load the pointer with `ptr_addr_o` |
| ptr_addr_o | output | 8 | Byte address received from the master |
| rd_data_i | input | 8 | Byte at the current pointer |
| rd_next_o | output | 1 | Strobe: a read byte was sent, advance the pointer |
| wbuf_wr_o | output | 1 | Strobe: store `wbuf_data_o` in the page buffer |
| wbuf_data_o | output | 8 | Data byte received from the master |
| wr_start_o | output | 1 | Strobe: launch the non-volatile write cycle |

## Verification
The properties assume a well-behaved master. SDA moves only while SCL is low, except to form START or STOP. The master never forms a START or STOP while the target is pulling SDA low. Each SCL phase lasts longer than the synchroniser delay plus two clocks. The bench master holds every SCL phase and every SDA setup for eight system clocks and changes `busy_i` and `wp_i` only between bit slots. This keeps the stimulus inside those assumptions, so the SCL-low rule for `sda_low_o` and the STOP-to-launch relation can be asserted without qualification.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } phase_t;
endpackage

// File: rtl/eei2c_sync.sv
module eei2c_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("eei2c_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("eei2c_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eei2c_cond.sv
module eei2c_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/eei2c_target.sv
module eei2c_target
   import eei2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_low_o,
   input  logic              busy_i,
   input  logic              wp_i,
   output logic              ptr_load_o,
   output logic [BYTE_W-1:0] ptr_addr_o,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              rd_next_o,
   output logic              wbuf_wr_o,
   output logic [BYTE_W-1:0] wbuf_data_o,
   output logic              wr_start_o
);
   localparam int                CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  FULL  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0]  LASTB = CNT_W'(BYTE_W - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("eei2c_target: SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s, wp_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   eei2c_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({wp_i, sda_i, scl_i}),
      .q_o   ({wp_s, sda_s, scl_s})
   );

   eei2c_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   phase_t            st, nxt;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              seen, first, wp_q, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         nxt         <= ST_IDLE;
         cnt         <= '0;
         shreg       <= '0;
         seen        <= 1'b0;
         first       <= 1'b0;
         wp_q        <= 1'b0;
         mack        <= 1'b0;
         sda_low_o   <= 1'b0;
         ptr_load_o  <= 1'b0;
         ptr_addr_o  <= '0;
         rd_next_o   <= 1'b0;
         wbuf_wr_o   <= 1'b0;
         wbuf_data_o <= '0;
         wr_start_o  <= 1'b0;
      end else begin
         ptr_load_o <= 1'b0;
         rd_next_o  <= 1'b0;
         wbuf_wr_o  <= 1'b0;
         wr_start_o <= 1'b0;
         if (start_det) begin
            st        <= ST_DEV;
            cnt       <= '0;
            sda_low_o <= 1'b0;
            seen      <= 1'b0;
         end else if (stop_det) begin
            st         <= ST_IDLE;
            sda_low_o  <= 1'b0;
            wr_start_o <= seen;
            seen       <= 1'b0;
         end else begin
            case (st)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  if (scl_rise && cnt != FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     cnt <= '0;
                     if (st == ST_DEV) begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR && !busy_i) begin
                           sda_low_o <= 1'b1;
                           st        <= ST_ACK;
                           nxt       <= shreg[0] ? ST_RDAT : ST_WADR;
                           first     <= 1'b1;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else if (st == ST_WADR) begin
                        sda_low_o  <= 1'b1;
                        st         <= ST_ACK;
                        nxt        <= ST_WDAT;
                        ptr_load_o <= 1'b1;
                        ptr_addr_o <= shreg;
                     end else if (first && wp_q) begin
                        st <= ST_SKIP;
                     end else begin
                        sda_low_o   <= 1'b1;
                        st          <= ST_ACK;
                        nxt         <= ST_WDAT;
                        wbuf_wr_o   <= 1'b1;
                        wbuf_data_o <= shreg;
                        seen        <= 1'b1;
                        first       <= 1'b0;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     st        <= nxt;
                     cnt       <= '0;
                     sda_low_o <= 1'b0;
                     if (nxt == ST_WDAT && first) wp_q <= wp_s;
                     if (nxt == ST_RDAT) begin
                        shreg     <= rd_data_i;
                        sda_low_o <= ~rd_data_i[BYTE_W-1];
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == LASTB) begin
                        sda_low_o <= 1'b0;
                        st        <= ST_RACK;
                        rd_next_o <= 1'b1;
                     end else begin
                        sda_low_o <= ~shreg[BYTE_W-2];
                        shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                        cnt       <= cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        st        <= ST_RDAT;
                        shreg     <= rd_data_i;
                        sda_low_o <= ~rd_data_i[BYTE_W-1];
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/eei2c_target_chk.sv
module eei2c_target_chk (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_s,
   input logic                stop_det,
   input eei2c_pkg::phase_t   st,
   input logic                sda_low_o,
   input logic                ptr_load_o,
   input logic                wbuf_wr_o,
   input logic                rd_next_o,
   input logic                wr_start_o
);
   import eei2c_pkg::*;

   // R12: the pull-down moves only while the synchronised clock line is low
   p_sda_low_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_low_o) |-> !scl_s);

   // R7: a launch strobe always follows a detected STOP
   p_launch_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> $past(stop_det));

   // R6: neighbour strobes never coincide
   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ptr_load_o, wbuf_wr_o, rd_next_o, wr_start_o}));

   // R3: an unaddressed or idle target keeps SDA released
   p_quiet_when_unaddressed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_SKIP) |-> !sda_low_o);

   // R10: SDA is free for the master's acknowledge after each read byte
   p_release_for_master_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_next_o |-> !sda_low_o);
endmodule

bind eei2c_target eei2c_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .stop_det   (stop_det),
   .st         (st),
   .sda_low_o  (sda_low_o),
   .ptr_load_o (ptr_load_o),
   .wbuf_wr_o  (wbuf_wr_o),
   .rd_next_o  (rd_next_o),
   .wr_start_o (wr_start_o)
);

// File: tb/tb_eei2c_target.sv
module tb_eei2c_target;
   localparam logic [6:0] DEV = 7'h50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       busy = 1'b0;
   logic       wp = 1'b0;
   logic       sda_low, ptr_load, rd_next, wbuf_wr, wr_start;
   logic [7:0] ptr_addr, rd_data, wbuf_data;
   logic       sda_line;

   assign sda_line = sda_m & ~sda_low;

   eei2c_target #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_low_o   (sda_low),
      .busy_i      (busy),
      .wp_i        (wp),
      .ptr_load_o  (ptr_load),
      .ptr_addr_o  (ptr_addr),
      .rd_data_i   (rd_data),
      .rd_next_o   (rd_next),
      .wbuf_wr_o   (wbuf_wr),
      .wbuf_data_o (wbuf_data),
      .wr_start_o  (wr_start)
   );

   always #2 clk = ~clk;

   // neighbour model: pointer, storage contents, page-buffer log
   logic [7:0] mem [256];
   logic [7:0] ptr = 8'h00;
   logic [7:0] last_load = 8'h00;
   logic [7:0] wq [$];
   int         n_launch = 0;
   int         n_load = 0;
   int         errors = 0;
   int         checks = 0;
   logic       prev_low = 1'b0;

   assign rd_data = mem[ptr];

   always @(negedge clk) begin
      if (rst_n) begin
         if (ptr_load) begin
            ptr = ptr_addr;
            last_load = ptr_addr;
            n_load++;
         end
         if (rd_next) ptr = ptr + 8'd1;
         if (wbuf_wr) wq.push_back(wbuf_data);
         if (wr_start) n_launch++;
         if (sda_low !== prev_low && scl_m) begin
            errors++;
            checks++;
            $display("FAIL R12: sda_low moved to %0b while SCL high (expected no change)", sda_low);
         end
      end
      prev_low = sda_low;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
   endtask

   task automatic clock_bit(input bit b, output bit s);
      sda_m = b; q(); scl_m = 1'b1; q(); s = sda_line; q(); scl_m = 1'b0; q();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
      clock_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         v[i] = s;
      end
      clock_bit(!mack, s);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit         ack, s;
      logic [7:0] v;
      int         launches;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      q();

      // R1: reset state, no response without START
      chk(sda_low == 1'b0, "R1 reset release", sda_low, 0);
      send_byte({DEV, 1'b0}, ack);
      chk(!ack, "R1 no ack without START", ack, 0);
      bus_stop();

      // R2 R5 R6 R7: two-byte write
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R2 write address ack", ack, 1);
      send_byte(8'h10, ack);
      chk(ack, "R5 byte address ack", ack, 1);
      chk(n_load == 1 && last_load == 8'h10, "R5 pointer load", last_load, 8'h10);
      send_byte(8'hA5, ack);
      chk(ack, "R6 first data ack", ack, 1);
      send_byte(8'h3C, ack);
      chk(ack, "R6 second data ack", ack, 1);
      bus_stop();
      q();
      chk(wq.size() == 2, "R6 buffer count", wq.size(), 2);
      if (wq.size() == 2) chk(wq[0] == 8'hA5 && wq[1] == 8'h3C, "R6 buffer order", {wq[0], wq[1]}, 16'hA53C);
      chk(n_launch == 1, "R7 one launch", n_launch, 1);
      wq.delete();

      // R3: wrong address, later bytes ignored
      bus_start();
      send_byte({7'h51, 1'b0}, ack);
      chk(!ack, "R3 mismatch nack", ack, 0);
      send_byte(8'h22, ack);
      chk(!ack, "R3 later byte ignored", ack, 0);
      bus_stop();
      q();
      chk(n_launch == 1 && wq.size() == 0, "R3 no write", n_launch, 1);

      // R4: busy refuses the address
      busy = 1'b1;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk(!ack, "R4 busy nack", ack, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R4 ack once idle", ack, 1);
      // R7: address only, then STOP, no launch
      send_byte(8'h05, ack);
      bus_stop();
      q();
      chk(n_launch == 1, "R7 no launch without data", n_launch, 1);

      // R8: WP high at sampling edge, dropped later
      wp = 1'b1;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h20, ack);
      wp = 1'b0;
      send_byte(8'h77, ack);
      chk(!ack, "R8 protected first data nack", ack, 0);
      bus_stop();
      q();
      chk(wq.size() == 0 && n_launch == 1, "R8 protected write dropped", n_launch, 1);

      // R8: WP rising after sampling edge has no effect
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h21, ack);
      wp = 1'b1;
      send_byte(8'h66, ack);
      chk(ack, "R8 late WP ignored", ack, 1);
      bus_stop();
      q();
      wp = 1'b0;
      chk(wq.size() == 1 && n_launch == 2, "R8 late WP write launched", n_launch, 2);
      wq.delete();

      // R9 R10 R11: selective read of three bytes
      launches = n_launch;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h40, ack);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk(ack, "R2 read address ack", ack, 1);
      recv_byte(1'b1, v);
      chk(v == mem[8'h40], "R11 selective first byte", v, mem[8'h40]);
      recv_byte(1'b1, v);
      chk(v == mem[8'h41], "R10 continued byte", v, mem[8'h41]);
      recv_byte(1'b0, v);
      chk(v == mem[8'h42], "R9 third byte msb first", v, mem[8'h42]);
      // after master NACK the line must stay released
      clock_bit(1'b1, s);
      chk(s == 1'b1, "R10 released after nack", s, 1);
      bus_stop();
      q();
      chk(n_launch == launches && wq.size() == 0, "R11 no write launched", n_launch, launches);

      // R9: immediate read continues at the advanced pointer
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b0, v);
      chk(v == mem[8'h43], "R9 immediate read", v, mem[8'h43]);
      bus_stop();
      q();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule